// File: doc/BRIEF.md
# Clock-Pair Enable Serial Configuration Slave

This block is the control side of a differential clock fanout buffer. A two-wire serial master (I2C-style signalling on SCL and an open-drain SDA) talks to it through block transfers. A write carries a command byte and a count byte, which the slave acknowledges and then drops. It then carries data bytes, which fill the configuration bank in order from byte 0. A read first returns a fixed count byte and then streams the bank out from byte 0. There is no random access. The master ends a read by not acknowledging a byte.

Two of the bank bytes hold per-pair enable bits for six differential clock pairs. The block gates a buffered reference clock onto each true/complement pair. A pair that is off holds true low and complement high. A new enable setting is carried into the reference clock domain and takes effect only while the reference is low, so a pair never emits a shortened pulse. The feedback output always follows the reference. The serial lines are oversampled by a system clock that runs at least eight times the bit rate.

Top module: `clkfan_cfg`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), from the 7-bit address 1101001. For any other address it NACKs and does not drive SDA until the next START.
- R2: In a write, the two bytes that follow the address are acknowledged and not stored. Each later data byte is stored at bank index 0, 1, 2 and so on, and is acknowledged.
- R3: In a read, the first byte returned is the count value 0x09. The following bytes are bank bytes from index 0 in ascending order, sent MSB first.
- R4: After reset, bank byte 6 reads 0x8F, byte 7 reads 0xFF and bytes 0-5 and 8 read 0x00. SDA is released and all six pairs are enabled.
- R5: Data bytes written past index 8 are acknowledged and discarded. Read bytes past index 8 return 0xFF.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and ignores further SCL pulses until the next START.
- R7: Pair enables are taken from these bits (1 = on): pair 5 = byte 6 bit 2, pair 4 = byte 6 bit 1, pair 3 = byte 6 bit 0, pair 2 = byte 7 bit 4, pair 1 = byte 7 bit 2, pair 0 = byte 7 bit 0. The other bits have no effect on the pairs.
- R8: An enabled pair drives true equal to the reference and complement as its inverse. A disabled pair holds true low and complement high. The feedback output always equals the reference.
- R9: A STOP or START that arrives in the middle of a byte abandons that byte without storing it. A START begins a new address phase.
- R10: Each change on a pair's true output matches the reference level at that moment. An enable change therefore never makes a shortened pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| ref_clk | input | 1 | Buffered reference clock |
| fb_clk | output | 1 | Ungated feedback copy of the reference |
| pair_t | output | 6 | True outputs of the clock pairs |
| pair_c | output | 6 | Complement outputs of the clock pairs |

## Verification
The bench writes patterns with mixed enable and reserved bits and reads them back whole. A slave that stored the command or count byte would show every data byte shifted by up to two places, and a wrong bit map would turn on the wrong pairs. It overruns the bank in both directions: a slave without saturation would wrap and corrupt byte 0, or would return stale data instead of 0xFF. It also cuts a byte short with STOP and with a repeated START, and it keeps clocking after a master NACK. A slave that stored partial bytes, did not resynchronise, or held SDA low would show the wrong values there. A monitor watches every edge of every pair output. An enable applied while the reference is high would show as a pair edge that does not match the reference.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/1ps
package clkfan_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RX_ACK,
        S_TX,
        S_TX_ACK,
        S_SKIP
    } link_st_e;

    typedef enum logic [1:0] {
        P_ADDR,
        P_CMD,
        P_CNT,
        P_DATA
    } link_ph_e;

    // Power-on contents of the configuration bank
    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            6:       return 8'h8F;
            7:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // Bank byte holding the enable of pair k
    function automatic int pair_byte(input int k);
        return (k < 3) ? 7 : 6;
    endfunction

    // Bit position inside that byte
    function automatic int pair_bit(input int k);
        case (k)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            3:       return 0;
            4:       return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/clkfan_sync.sv
`timescale 1ns/1ps
module clkfan_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/clkfan_link.sv
`timescale 1ns/1ps
module clkfan_link
    import clkfan_pkg::*;
#(
    parameter logic [6:0] ADDR7   = 7'h69,
    parameter int         NBYTES  = 9,
    parameter logic [7:0] CNT_VAL = 8'h09,
    parameter int         IDX_W   = $clog2(NBYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_addr,
    input  logic [7:0]       rd_data
);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NBYTES);

    typedef struct packed {
        link_st_e         st;
        link_ph_e         ph;
        logic [7:0]       sh;
        logic [3:0]       bits;
        logic             is_rd;
        logic             nack;
        logic [IDX_W-1:0] idx;
        logic             oe;
        logic             scl_p;
        logic             sda_p;
        logic             wr_en;
        logic [IDX_W-1:0] wr_addr;
        logic [7:0]       wr_data;
    } link_t;

    link_t q, d;
    logic  scl_rise, scl_fall, start_ev, stop_ev;
    logic [IDX_W-1:0] idx_next;

    assign scl_rise = scl_s & ~q.scl_p;
    assign scl_fall = ~scl_s & q.scl_p;
    assign start_ev = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_ev  = scl_s & q.scl_p & ~q.sda_p & sda_s;
    assign idx_next = (q.idx == IDX_END) ? q.idx : q.idx + IDX_W'(1);

    always_comb begin
        d       = q;
        d.scl_p = scl_s;
        d.sda_p = sda_s;
        d.wr_en = 1'b0;
        if (start_ev) begin
            d.st    = S_RX;
            d.ph    = P_ADDR;
            d.bits  = '0;
            d.oe    = 1'b0;
            d.idx   = '0;
            d.is_rd = 1'b0;
        end else if (stop_ev) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                S_RX: begin
                    if (scl_rise && q.bits < 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        d.bits = '0;
                        d.st   = S_RX_ACK;
                        d.oe   = 1'b1;
                        case (q.ph)
                            P_ADDR: begin
                                if (q.sh[7:1] == ADDR7) begin
                                    d.is_rd = q.sh[0];
                                    d.ph    = q.sh[0] ? P_CNT : P_CMD;
                                end else begin
                                    d.st = S_SKIP;
                                    d.oe = 1'b0;
                                end
                            end
                            P_CMD:   d.ph = P_CNT;
                            P_CNT:   d.ph = P_DATA;
                            default: begin
                                if (q.idx != IDX_END) begin
                                    d.wr_en   = 1'b1;
                                    d.wr_addr = q.idx;
                                    d.wr_data = q.sh;
                                    d.idx     = idx_next;
                                end
                            end
                        endcase
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        if (q.is_rd) begin
                            d.st   = S_TX;
                            d.sh   = CNT_VAL;
                            d.oe   = ~CNT_VAL[7];
                            d.bits = 4'd1;
                        end else begin
                            d.st = S_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.bits == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = S_TX_ACK;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.oe   = ~q.sh[6];
                            d.bits = q.bits + 4'd1;
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.st = S_IDLE;
                        end else begin
                            d.st   = S_TX;
                            d.ph   = P_DATA;
                            d.sh   = rd_data;
                            d.oe   = ~rd_data[7];
                            d.bits = 4'd1;
                            d.idx  = idx_next;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.ph    <= P_ADDR;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign rd_addr = q.idx;

    // R1 / R6: the line is pulled only while acknowledging or sending
    a_r1_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (q.st == S_RX_ACK || q.st == S_TX));

    // R9: a STOP always leaves the slave idle with SDA released
    a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (q.st == S_IDLE && !sda_oe));

    // R5: the byte pointer saturates at the end of the bank
    a_r5_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IDX_END);

    // R2: stores come only from data bytes of a write transfer
    a_r2_store_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (q.ph == P_DATA && !q.is_rd));
endmodule

// File: rtl/clkfan_regs.sv
`timescale 1ns/1ps
module clkfan_regs
    import clkfan_pkg::*;
#(
    parameter int NBYTES = 9,
    parameter int NPAIRS = 6,
    parameter int IDX_W  = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [7:0]        rd_data,
    output logic [NPAIRS-1:0] pair_en
);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NBYTES);

    logic [7:0] mem_q [NBYTES];
    logic [7:0] mem_d [NBYTES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en && wr_addr < IDX_END) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) begin
                mem_q[i] <= reg_reset(i);
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = (rd_addr < IDX_END) ? mem_q[rd_addr] : 8'hFF;

    for (genvar k = 0; k < NPAIRS; k++) begin : g_map
        assign pair_en[k] = mem_q[pair_byte(k)][pair_bit(k)];
    end

    // R5: the protocol side never issues a store outside the bank
    a_r5_store_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_addr < IDX_END);
endmodule

// File: rtl/clkfan_gate.sv
`timescale 1ns/1ps
module clkfan_gate #(
    parameter bit RST_EN = 1'b1
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic en_async,
    output logic pair_t,
    output logic pair_c
);
    logic s1_q, s2_q, en_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_EN;
            s2_q <= RST_EN;
        end else begin
            s1_q <= en_async;
            s2_q <= s1_q;
        end
    end

    // Updated on the falling edge: the enable only moves while ref_clk is low
    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) en_q <= RST_EN;
        else        en_q <= s2_q;
    end

    assign pair_t = ref_clk & en_q;
    assign pair_c = ~pair_t;
endmodule

// File: rtl/clkfan_cfg.sv
`timescale 1ns/1ps
module clkfan_cfg
    import clkfan_pkg::*;
#(
    parameter logic [6:0] ADDR7   = 7'h69,
    parameter int         NBYTES  = 9,
    parameter logic [7:0] CNT_VAL = 8'h09,
    parameter int         NPAIRS  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              ref_clk,
    output logic              fb_clk,
    output logic [NPAIRS-1:0] pair_t,
    output logic [NPAIRS-1:0] pair_c
);
    localparam int IDX_W = $clog2(NBYTES + 1);

    logic [1:0]        line_s;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_addr, rd_addr;
    logic [7:0]        wr_data, rd_data;
    logic [NPAIRS-1:0] pair_en;

    clkfan_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );

    clkfan_link #(
        .ADDR7(ADDR7), .NBYTES(NBYTES), .CNT_VAL(CNT_VAL), .IDX_W(IDX_W)
    ) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (line_s[1]),
        .sda_s   (line_s[0]),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    clkfan_regs #(.NBYTES(NBYTES), .NPAIRS(NPAIRS), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pair_en (pair_en)
    );

    for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
        localparam logic [7:0] RBYTE = reg_reset(pair_byte(k));
        localparam bit         REN   = RBYTE[pair_bit(k)];
        clkfan_gate #(.RST_EN(REN)) u_gate (
            .ref_clk  (ref_clk),
            .rst_n    (rst_n),
            .en_async (pair_en[k]),
            .pair_t   (pair_t[k]),
            .pair_c   (pair_c[k])
        );
    end

    assign fb_clk = ref_clk;
endmodule

// File: tb/clkfan_cfg_bench.sv
`timescale 1ns/1ps
module clkfan_cfg_bench;
    localparam int Q = 10;

    logic       clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
    logic       scl = 1'b1, m_low = 1'b0;
    logic       sda_line, sda_oe, fb_clk;
    logic [5:0] pair_t, pair_c;
    int         n_chk = 0, n_fail = 0, runt_err = 0, cyc = 0;
    logic [7:0] wbuf [0:15];
    logic [7:0] rbuf [0:15];
    logic [5:0] pt_prev = 6'h00;
    bit         mon_on = 1'b0;

    assign sda_line = ~(m_low | sda_oe);

    always #2 clk = ~clk;
    always #7 ref_clk = ~ref_clk;

    clkfan_cfg u_clkfan_cfg (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .ref_clk(ref_clk), .fb_clk(fb_clk), .pair_t(pair_t), .pair_c(pair_c)
    );

    // R10 monitor: every true-output edge must coincide with the reference level
    always @(pair_t) begin
        if (mon_on) begin
            for (int k = 0; k < 6; k++)
                if (pair_t[k] != pt_prev[k] && pair_t[k] != ref_clk) runt_err++;
        end
        pt_prev = pair_t;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ackd);
        send_bits(b, 8);
        m_low = 1'b0; wq(); scl = 1'b1; wq(); ackd = ~sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
        end
        m_low = give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); m_low = 1'b0;
    endtask

    task automatic write_block(input int n, input logic [7:0] cmd, input logic [7:0] cnt, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        i2c_start();
        send_byte(8'hD2, a); all_ack &= a;
        send_byte(cmd, a);   all_ack &= a;
        send_byte(cnt, a);   all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); all_ack &= a;
        end
        i2c_stop();
    endtask

    task automatic read_block(input int n, output bit ackd);
        logic [7:0] b;
        i2c_start();
        send_byte(8'hD3, ackd);
        for (int i = 0; i <= n; i++) begin
            recv_byte(i < n, b);
            rbuf[i] = b;
        end
        i2c_stop();
    endtask

    task automatic check_pairs(input logic [5:0] exp, input string req);
        repeat (6) @(posedge ref_clk);
        @(posedge ref_clk); #2;
        check(pair_t == exp && pair_c == ~exp && fb_clk, req, {20'd0, fb_clk, pair_t, pair_c}, {20'd0, 1'b1, exp, ~exp});
        @(negedge ref_clk); #2;
        check(pair_t == 6'h00 && pair_c == 6'h3F && !fb_clk, req, {20'd0, fb_clk, pair_t, pair_c}, {20'd0, 1'b0, 6'h00, 6'h3F});
    endtask

    task automatic t_reset();
        bit a;
        check(sda_oe == 1'b0, "R4 sda released", {31'd0, sda_oe}, 32'd0);
        check_pairs(6'h3F, "R4/R8 pairs after reset");
        read_block(9, a);
        check(a, "R1 read address 0xD3 ack", {31'd0, a}, 32'd1);
        check(rbuf[0] == 8'h09, "R3 count byte", {24'd0, rbuf[0]}, 32'h09);
        for (int i = 0; i < 9; i++) begin
            logic [7:0] e;
            e = (i == 6) ? 8'h8F : (i == 7) ? 8'hFF : 8'h00;
            check(rbuf[i + 1] == e, "R4 reset value", {24'd0, rbuf[i + 1]}, {24'd0, e});
        end
    endtask

    task automatic t_write_map();
        bit a;
        logic [7:0] pat [0:8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h05, 8'hEE, 8'h99};
        for (int i = 0; i < 9; i++) wbuf[i] = pat[i];
        write_block(9, 8'h06, 8'h09, a);
        check(a, "R1/R2 write bytes acknowledged", {31'd0, a}, 32'd1);
        read_block(9, a);
        for (int i = 0; i < 9; i++)
            check(rbuf[i + 1] == pat[i], "R2 data stored from byte 0, command/count dropped", {24'd0, rbuf[i + 1]}, {24'd0, pat[i]});
        // byte6=0x05 -> pairs 5,3 on; byte7=0xEE -> pair 1 on
        check_pairs(6'b101010, "R7/R8 enable mapping");
    endtask

    task automatic t_beyond();
        bit a;
        logic [7:0] pat [0:10] = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'h07, 8'h15, 8'hA8, 8'h5A, 8'hC3};
        for (int i = 0; i < 11; i++) wbuf[i] = pat[i];
        write_block(11, 8'h00, 8'h0B, a);
        check(a, "R5 overrun bytes acknowledged", {31'd0, a}, 32'd1);
        read_block(12, a);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] e;
            e = (i < 9) ? pat[i] : 8'hFF;
            check(rbuf[i + 1] == e, "R5 bank after overrun", {24'd0, rbuf[i + 1]}, {24'd0, e});
        end
        check_pairs(6'h3F, "R7 all pairs re-enabled");
    endtask

    task automatic t_bad_addr();
        bit a;
        i2c_start();
        send_byte(8'hA4, a);
        check(!a, "R1 foreign address NACKed", {31'd0, a}, 32'd0);
        send_byte(8'hD2, a);
        check(!a, "R1 silent until next START", {31'd0, a}, 32'd0);
        i2c_stop();
    endtask

    task automatic t_nack();
        bit a;
        logic [7:0] b;
        i2c_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, b);
        check(b == 8'h09, "R3 count first", {24'd0, b}, 32'h09);
        recv_byte(1'b1, b);
        check(b == 8'hA0, "R3 byte 0 next", {24'd0, b}, 32'hA0);
        recv_byte(1'b0, b);
        check(b == 8'hA1, "R3 byte 1 next", {24'd0, b}, 32'hA1);
        recv_byte(1'b1, b);
        check(b == 8'hFF && !sda_oe, "R6 released after master NACK", {23'd0, sda_oe, b}, 32'h0FF);
        i2c_stop();
    endtask

    task automatic t_abort();
        bit a;
        logic [7:0] b;
        i2c_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_bits(8'h00, 7);
        i2c_stop();
        read_block(1, a);
        check(rbuf[1] == 8'hA0, "R9 STOP mid-byte stores nothing", {24'd0, rbuf[1]}, 32'hA0);
        i2c_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_bits(8'h3C, 5);
        i2c_start();
        send_byte(8'hD3, a);
        check(a, "R9 repeated START restarts address phase", {31'd0, a}, 32'd1);
        recv_byte(1'b1, b);
        recv_byte(1'b0, b);
        check(b == 8'hA0, "R9 byte 0 intact after START abort", {24'd0, b}, 32'hA0);
        i2c_stop();
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge ref_clk);
        mon_on = 1'b1;
        t_reset();
        t_write_map();
        t_beyond();
        t_bad_addr();
        t_nack();
        t_abort();
        check(runt_err == 0, "R10 no shortened pair pulse", runt_err, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule